// File: doc/BRIEF.md
# External Parallel Bus Access Controller

This block turns single internal read and write requests into cycles on an external parallel bus with a 24-bit address and a 16-bit data path. Each bus cycle spans two system clocks. A plain access takes three bus cycles: an address cycle with the address-latch strobe, a strobe cycle, and a data cycle at whose end read data is captured and the strobe is released. When enabled, a ready input stretches the strobe with extra wait cycles. The address and data can share the low sixteen pins (multiplexed) or use separate pins (non-multiplexed). In both cases the full address is also driven on the address output.

Every request names a region (lower memory, upper memory or I/O) and a size (byte or 16-bit word). A per-region width bit, or a global 8-bit bus setting, makes the access narrow. Narrow accesses use only data bits 7:0. A narrow word request becomes two byte beats, and the block returns one assembled result with a single done pulse. Read data comes back on `rd_data`, qualified by a one-clock `done`.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, `bus_rd_n`, `bus_wrl_n` and `bus_wrh_n` are high, and `bus_ale`, `bus_clk`, `bus_dq_oe`, `busy` and `done` are low.
- R2: Each beat lasts three bus cycles of two clocks each, and `bus_clk` is high in the first clock of each bus cycle. With ready disabled, `done` is high in the cycle after the 6×beats-th rising edge that follows the accepting edge.
- R3: `bus_ale` is high for the whole first bus cycle of every beat with all strobes high, and a read or write strobe is always asserted in the bus cycle right after it, so the bus never shows an address-latch pulse without a transfer.
- R4: In multiplexed mode (`cfg_mux`=1), `bus_dq_o` carries beat address bits 15:0 with `bus_dq_oe`=1 during the address cycle. In non-multiplexed mode, `bus_dq_oe` is 0 during that cycle. `bus_addr` carries the full 24-bit beat address throughout a beat.
- R5: A read holds `bus_rd_n` low from the second bus cycle to the end of the third. It captures `bus_dq_i` on the last clock of the third bus cycle and presents the result on `rd_data` while `done` is high.
- R6: A write drives `bus_dq_oe`=1 and the lane data on `bus_dq_o` while its write strobes are low. `bus_wrl_n` is the strobe for bits 7:0 and `bus_wrh_n` the strobe for bits 15:8.
- R7: With `cfg_ready_en`=1, if `bus_ready` is low at the last clock of the strobe cycle or of a wait cycle, one more two-clock wait cycle follows with the strobe held. With `cfg_ready_en`=0, `bus_ready` has no effect.
- R8: With `cfg_bus16`=1, the access is narrow when the width bit of its region is 1. `cfg_width8` bit 0 is lower memory (`req_region`=0), bit 1 is upper memory (1), and bit 2 is I/O (2, and 3 also maps to I/O).
- R9: A narrow beat transfers on bits 7:0 only. `bus_wrh_n` stays high, and `bus_dq_o[15:8]` is driven as zero on writes.
- R10: A narrow word request makes two beats: first at the address with bit 0 cleared (byte to/from bits 7:0 of the word), then at that address plus one (bits 15:8). One `done` follows the second beat.
- R11: On a 16-bit region, a word access uses the address with bit 0 cleared and both write strobes. A byte access uses `bus_wrl_n`/bits 7:0 when address bit 0 is 0 and `bus_wrh_n`/bits 15:8 when it is 1. A byte write places its byte on both lanes, and a byte read returns the selected byte zero-extended.
- R12: `req_valid` is only taken when the block is idle and `done` is low. A request raised while `busy` is high is ignored and produces no bus activity.
- R13: With `cfg_bus16`=0, every access is narrow whatever `cfg_width8` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus16 | input | 1 | 1: 16-bit external bus, 0: 8-bit bus |
| cfg_mux | input | 1 | 1: address shares data pins in the address cycle |
| cfg_ready_en | input | 1 | Enables wait insertion from `bus_ready` |
| cfg_width8 | input | 3 | Per-region narrow bits: lower mem, upper mem, I/O |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1: write, 0: read |
| req_size16 | input | 1 | 1: word, 0: byte |
| req_region | input | 2 | Region select |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| bus_clk | output | 1 | Bus clock, high in first half of each bus cycle |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wrl_n | output | 1 | Low-byte write strobe, active low |
| bus_wrh_n | output | 1 | High-byte write strobe, active low |
| bus_addr | output | 24 | Beat address |
| bus_dq_o | output | 16 | Data/address out |
| bus_dq_oe | output | 1 | Output enable for `bus_dq_o` |
| bus_dq_i | input | 16 | Data in |
| bus_ready | input | 1 | External ready, high to finish |

## Verification
The accepting edge is recorded, and `done` is due at the negedge after edge 6×beats+2×waits, counted from the accepting edge. Wait cycles are counted only when ready is enabled. Per-beat results are checked at negedges while they are live. The address-cycle properties are checked while `bus_ale` is high. Each write beat is checked when its strobe returns high, against the beat the scoreboard expects next. The returned word and the latency are checked in the `done` cycle. The device model answers with bytes computed from the address, so a lane or width error changes the read value.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int EBC_AW = 24;
  localparam int EBC_DW = 16;
  localparam int EBC_BW = 8;
  localparam int EBC_NREG = 3;
  localparam int EBC_RW = $clog2(EBC_NREG + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_STRB, S_WAIT, S_DATA
  } ebc_st_e;

  // narrow when the whole bus is 8 bits or the region asks for 8 bits
  function automatic logic f_narrow(input logic bus16, input logic [EBC_NREG-1:0] w8,
                                    input logic [EBC_RW-1:0] region);
    logic [EBC_RW-1:0] idx;
    idx = (region >= EBC_RW'(EBC_NREG)) ? EBC_RW'(EBC_NREG - 1) : region;
    return !bus16 || w8[idx];
  endfunction

  // byte-lane enables {high, low}
  function automatic logic [1:0] f_lanes(input logic narrow, input logic size16,
                                         input logic a0);
    if (narrow) return 2'b01;
    if (size16) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [EBC_AW-1:0] f_beat_addr(input logic [EBC_AW-1:0] a,
                                                   input logic size16, input logic beat);
    if (size16) return {a[EBC_AW-1:1], beat};
    return a;
  endfunction

  function automatic logic [EBC_DW-1:0] f_wlanes(input logic narrow, input logic size16,
                                                 input logic beat,
                                                 input logic [EBC_DW-1:0] wd);
    if (narrow)
      return {{EBC_BW{1'b0}}, (size16 && beat) ? wd[EBC_DW-1:EBC_BW] : wd[EBC_BW-1:0]};
    if (size16) return wd;
    return {wd[EBC_BW-1:0], wd[EBC_BW-1:0]};
  endfunction

  function automatic logic [EBC_DW-1:0] f_merge(input logic narrow, input logic size16,
                                                input logic beat, input logic a0,
                                                input logic [EBC_DW-1:0] acc,
                                                input logic [EBC_DW-1:0] dq);
    if (narrow) begin
      if (size16 && beat) return {dq[EBC_BW-1:0], acc[EBC_BW-1:0]};
      return {{EBC_BW{1'b0}}, dq[EBC_BW-1:0]};
    end
    if (size16) return dq;
    return {{EBC_BW{1'b0}}, a0 ? dq[EBC_DW-1:EBC_BW] : dq[EBC_BW-1:0]};
  endfunction
endpackage

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    split,
  input  logic    ready_en,
  input  logic    ready,
  output ebc_st_e st,
  output logic    ph,
  output logic    beat,
  output logic    ale_win,
  output logic    strb_win,
  output logic    smp,
  output logic    fin
);
  logic more_beats;

  assign more_beats = split && !beat;
  assign ale_win    = (st == S_ADDR);
  assign strb_win   = (st == S_STRB) || (st == S_WAIT) || (st == S_DATA);
  assign smp        = (st == S_DATA) && ph;
  assign fin        = smp && !more_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= 1'b0;
      beat <= 1'b0;
    end else if (st == S_IDLE) begin
      ph <= 1'b0;
      if (start) begin
        st   <= S_ADDR;
        beat <= 1'b0;
      end
    end else begin
      ph <= ~ph;
      if (ph) begin
        unique case (st)
          S_ADDR: st <= S_STRB;
          S_STRB: st <= (ready_en && !ready) ? S_WAIT : S_DATA;
          S_WAIT: st <= ready ? S_DATA : S_WAIT;
          S_DATA: begin
            if (more_beats) begin
              st   <= S_ADDR;
              beat <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3: an address cycle always runs into a strobe cycle
  assert_ale_then_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && ph) |=> (st == S_STRB));
  // R7: with ready disabled the strobe cycle goes straight to data
  assert_no_wait_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRB && ph && !ready_en) |=> (st == S_DATA));
  // R2: each bus cycle is two clocks
  assert_two_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !ph) |=> ($stable(st) && ph));
endmodule

// File: rtl/ebc_rdasm.sv
module ebc_rdasm
  import ebc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic              narrow,
  input  logic              size16,
  input  logic              beat,
  input  logic              a0,
  input  logic [EBC_DW-1:0] dq_i,
  output logic [EBC_DW-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (smp) acc <= f_merge(narrow, size16, beat, a0, acc, dq_i);
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int AW = EBC_AW,
  parameter int DW = EBC_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bus16,
  input  logic          cfg_mux,
  input  logic          cfg_ready_en,
  input  logic [2:0]    cfg_width8,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_size16,
  input  logic [1:0]    req_region,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          bus_clk,
  output logic          bus_ale,
  output logic          bus_rd_n,
  output logic          bus_wrl_n,
  output logic          bus_wrh_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [DW-1:0] bus_dq_i,
  input  logic          bus_ready
);
  localparam int AL = (AW < DW) ? AW : DW;

  ebc_st_e       st;
  logic          ph, beat, ale_win, strb_win, smp, fin, start;
  logic          l_write, l_size16, l_narrow, l_mux, l_ready_en;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata, acc, wl;
  logic [AW-1:0] b_addr;
  logic [1:0]    lanes;

  assign start = req_valid && (st == S_IDLE) && !done;
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_write <= 1'b0; l_size16 <= 1'b0; l_narrow <= 1'b0;
      l_mux <= 1'b0; l_ready_en <= 1'b0;
      l_addr <= '0; l_wdata <= '0;
    end else if (start) begin
      l_write    <= req_write;
      l_size16   <= req_size16;
      l_narrow   <= f_narrow(cfg_bus16, cfg_width8, req_region);
      l_mux      <= cfg_mux;
      l_ready_en <= cfg_ready_en;
      l_addr     <= req_addr;
      l_wdata    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin;
  end

  ebc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .split(l_narrow && l_size16),
    .ready_en(l_ready_en), .ready(bus_ready), .st(st), .ph(ph), .beat(beat),
    .ale_win(ale_win), .strb_win(strb_win), .smp(smp), .fin(fin)
  );

  ebc_rdasm u_rd (
    .clk(clk), .rst_n(rst_n), .smp(smp && !l_write), .narrow(l_narrow),
    .size16(l_size16), .beat(beat), .a0(l_addr[0]), .dq_i(bus_dq_i), .acc(acc)
  );

  assign b_addr = f_beat_addr(l_addr, l_size16, beat);
  assign lanes  = f_lanes(l_narrow, l_size16, l_addr[0]);
  assign wl     = f_wlanes(l_narrow, l_size16, beat, l_wdata);

  assign rd_data   = acc;
  assign bus_clk   = busy && !ph;
  assign bus_ale   = ale_win;
  assign bus_addr  = busy ? b_addr : '0;
  assign bus_rd_n  = !(strb_win && !l_write);
  assign bus_wrl_n = !(strb_win && l_write && lanes[0]);
  assign bus_wrh_n = !(strb_win && l_write && lanes[1]);
  assign bus_dq_oe = (ale_win && l_mux) || (strb_win && l_write);

  always_comb begin
    bus_dq_o = '0;
    if (ale_win && l_mux)        bus_dq_o[AL-1:0] = b_addr[AL-1:0];
    else if (strb_win && l_write) bus_dq_o = wl;
  end

  // R1: strobes released whenever idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_rd_n && bus_wrl_n && bus_wrh_n && !bus_ale && !bus_dq_oe));
  // R3: no strobe during the address cycle
  assert_ale_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wrl_n && bus_wrh_n));
  // R6: read and write strobes never overlap
  assert_rd_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_wrl_n && bus_wrh_n));
  // R9: narrow accesses never use the high strobe
  assert_narrow_low_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && l_narrow) |-> bus_wrh_n);
  // R10: done is a single-clock pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12: a request during an access leaves the latched request alone
  assert_busy_ignores_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(l_addr));
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_bus16 = 1'b1, cfg_mux = 1'b0, cfg_ready_en = 1'b0;
  logic [2:0] cfg_width8 = 3'b000;
  logic req_valid = 1'b0, req_write = 1'b0, req_size16 = 1'b0;
  logic [1:0] req_region = 2'd0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, bus_clk, bus_ale, bus_rd_n, bus_wrl_n, bus_wrh_n, bus_dq_oe;
  logic [15:0] rd_data, bus_dq_o, bus_dq_i;
  logic [23:0] bus_addr;
  logic bus_ready;

  int n_run = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  bit dev8 = 1'b0;
  int wpb = 0, wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  ext_bus_ctrl u0 (.*);

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // external device: wide or narrow, ready low for wpb bus cycles per beat
  assign bus_dq_i  = dev8 ? {8'hEE, mb(bus_addr)}
                          : {mb(bus_addr | 24'h1), mb(bus_addr & ~24'h1)};
  assign bus_ready = (wait_cnt == 0);
  always @(posedge clk) begin
    if (bus_ale) wait_cnt <= wpb;
    else if (!(bus_rd_n && bus_wrl_n && bus_wrh_n) && !bus_clk && wait_cnt > 0)
      wait_cnt <= wait_cnt - 1;
  end

  typedef struct { logic [23:0] a; logic [1:0] m; logic [15:0] d; } wexp_t;
  typedef struct { bit rd; logic [15:0] d; int lat; string tag; } dexp_t;
  wexp_t wq[$];
  dexp_t dq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: bus phases, write beats, completions
  bit prev_ale = 0, prev_wr = 0;
  logic [23:0] c_a; logic [1:0] c_m; logic [15:0] c_d; bit c_oe;
  always @(negedge clk) begin
    bit wr_now;
    wr_now = !(bus_wrl_n && bus_wrh_n);
    if (rst_n) begin
      if (bus_ale) begin
        chk(bus_rd_n && bus_wrl_n && bus_wrh_n, "R3 strobes high in address cycle",
            {29'd0, bus_rd_n, bus_wrl_n, bus_wrh_n}, 32'h7);
        if (!prev_ale) chk(bus_clk == 1'b1, "R2 bus_clk high in first half", bus_clk, 1);
        if (u0.cfg_mux == cfg_mux && cfg_mux)
          chk(bus_dq_oe && bus_dq_o == bus_addr[15:0], "R4 mux address on data pins",
              bus_dq_o, bus_addr[15:0]);
        else
          chk(!bus_dq_oe, "R4 non-mux pins released in address cycle", bus_dq_oe, 0);
      end
      if (prev_ale && !bus_ale)
        chk(!(bus_rd_n && bus_wrl_n && bus_wrh_n), "R3 strobe follows address cycle",
            {29'd0, bus_rd_n, bus_wrl_n, bus_wrh_n}, 32'h0);
      if (wr_now) begin
        c_a = bus_addr; c_m = {!bus_wrh_n, !bus_wrl_n}; c_d = bus_dq_o; c_oe = bus_dq_oe;
      end
      if (prev_wr && !wr_now) begin
        if (wq.size() == 0) chk(0, "R12 unexpected write beat", c_a, 0);
        else begin
          wexp_t e;
          e = wq.pop_front();
          chk(c_a == e.a, "R10/R11 write beat address", c_a, e.a);
          chk(c_m == e.m, "R6/R9/R11 write lanes", c_m, e.m);
          chk(c_oe && c_d == e.d, "R6/R9 write data", c_d, e.d);
        end
      end
      if (done) begin
        if (dq.size() == 0) chk(0, "R12 unexpected done", 1, 0);
        else begin
          dexp_t e;
          e = dq.pop_front();
          chk(cyc - acc_cyc == e.lat, {e.tag, " done latency R2/R7"}, cyc - acc_cyc, e.lat);
          if (e.rd) chk(rd_data == e.d, {e.tag, " read data R5"}, rd_data, e.d);
        end
      end
    end
    prev_ale = bus_ale;
    prev_wr  = wr_now;
  end

  task automatic issue(input string tag, input bit wr, input bit s16, input logic [1:0] rg,
                       input logic [23:0] a, input logic [15:0] wd, input int nw);
    bit nar;
    int beats, lat;
    logic [1:0] idx;
    idx = (rg == 2'd3) ? 2'd2 : rg;
    nar = !cfg_bus16 || cfg_width8[idx];
    beats = (nar && s16) ? 2 : 1;
    lat = beats * (6 + (cfg_ready_en ? 2 * nw : 0));
    @(negedge clk);
    dev8 = nar; wpb = nw;
    if (wr) begin
      if (nar && s16) begin
        wq.push_back('{a & ~24'h1, 2'b01, {8'h00, wd[7:0]}});
        wq.push_back('{a | 24'h1, 2'b01, {8'h00, wd[15:8]}});
      end else if (nar) wq.push_back('{a, 2'b01, {8'h00, wd[7:0]}});
      else if (s16)     wq.push_back('{a & ~24'h1, 2'b11, wd});
      else              wq.push_back('{a, a[0] ? 2'b10 : 2'b01, {wd[7:0], wd[7:0]}});
    end
    dq.push_back('{!wr, s16 ? {mb(a | 24'h1), mb(a & ~24'h1)} : {8'h00, mb(a)}, lat, tag});
    req_valid = 1; req_write = wr; req_size16 = s16; req_region = rg;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 0;
    while (dq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bus_rd_n && bus_wrl_n && bus_wrh_n && !bus_ale && !bus_clk && !bus_dq_oe &&
        !busy && !done, "R1 reset idle outputs",
        {bus_rd_n, bus_wrl_n, bus_wrh_n, bus_ale, bus_clk, bus_dq_oe, busy, done}, 8'hE0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // wide region, non-mux: word and byte accesses (R5 R6 R11)
    issue("R11 wide word write", 1, 1, 2'd0, 24'h12_3457, 16'hBEEF, 0);
    issue("R11 wide word read",  0, 1, 2'd0, 24'h12_3456, 16'h0, 0);
    issue("R11 wide byte write odd", 1, 0, 2'd1, 24'hA0_0011, 16'h0077, 0);
    issue("R11 wide byte write even", 1, 0, 2'd1, 24'hA0_0010, 16'h0066, 0);
    issue("R11 wide byte read odd",  0, 0, 2'd0, 24'h00_4321, 16'h0, 0);
    issue("R11 wide byte read even", 0, 0, 2'd0, 24'h00_4320, 16'h0, 0);

    // multiplexed mode (R4)
    cfg_mux = 1;
    issue("R4 mux word read", 0, 1, 2'd1, 24'h7F_FFFE, 16'h0, 0);
    issue("R4 mux word write", 1, 1, 2'd1, 24'h01_0200, 16'h1234, 0);

    // per-region width (R8 R9 R10)
    cfg_width8 = 3'b100;
    issue("R8 io narrow word write", 1, 1, 2'd2, 24'h00_0F00, 16'hCAFE, 0);
    issue("R8 region3 narrow word read", 0, 1, 2'd3, 24'h00_0F11, 16'h0, 0);
    issue("R8 lower mem still wide read", 0, 1, 2'd0, 24'h00_0F10, 16'h0, 0);
    cfg_width8 = 3'b010;
    issue("R9 narrow byte write odd", 1, 0, 2'd1, 24'h33_3333, 16'h00A5, 0);
    issue("R9 narrow byte read odd", 0, 0, 2'd1, 24'h33_3333, 16'h0, 0);

    // 8-bit bus (R13)
    cfg_mux = 0; cfg_bus16 = 0; cfg_width8 = 3'b000;
    issue("R13 8-bit bus word read", 0, 1, 2'd0, 24'h55_AA00, 16'h0, 0);
    issue("R13 8-bit bus word write", 1, 1, 2'd1, 24'h55_AA03, 16'h9876, 0);

    // ready (R7)
    cfg_bus16 = 1; cfg_ready_en = 1;
    issue("R7 one wait read", 0, 1, 2'd0, 24'h00_1000, 16'h0, 1);
    issue("R7 three wait write", 1, 1, 2'd0, 24'h00_2000, 16'h4444, 3);
    cfg_width8 = 3'b001;
    issue("R7 waits each narrow beat", 0, 1, 2'd0, 24'h00_3002, 16'h0, 2);
    cfg_width8 = 3'b000; cfg_ready_en = 0;
    issue("R7 ready ignored when off", 0, 1, 2'd0, 24'h00_4000, 16'h0, 3);

    // R12: request during busy is ignored
    @(negedge clk);
    dev8 = 0; wpb = 0;
    wq.push_back('{24'h06_0000, 2'b11, 16'h1111});
    dq.push_back('{0, 16'h0, 6, "R12 first write"});
    req_valid = 1; req_write = 1; req_size16 = 1; req_region = 0;
    req_addr = 24'h06_0000; req_wdata = 16'h1111;
    @(negedge clk);
    acc_cyc = cyc;
    req_addr = 24'h06_0100; req_wdata = 16'h2222;
    repeat (2) @(negedge clk);
    req_valid = 0;
    while (dq.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(!busy && wq.size() == 0, "R12 no access from request during busy",
        {busy, wq.size() != 0}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule